// File: doc/BRIEF.md
# VBI Caption Line Selector

This block tracks video lines during the vertical blanking interval and tells a downstream data slicer which lines carry closed-caption data. It takes separated horizontal and vertical sync pulses and runs a line counter from them. It raises a slice enable for the whole of two lines in every field: a fixed caption line (count 21) and one line chosen by software. Both fields are handled the same way.

The block also produces a one-cycle strobe at the start of the line whose clock run-in is used to set the slicer's reference level. A two-bit selector in the position register picks that line. A field-select bit in the control register decides in which field the strobe fires. The block keeps a field flag that changes only when vertical sync falls. Software writes the two registers at any time. The block holds each write and applies it at the next vertical sync fall, so the configuration never changes in the middle of a field.

Top module: `vbi_line_sel`

## Requirements
- R1: `line_cnt_o` becomes 0 after a falling edge of `vsep_i`. It then rises by exactly one for each `hsep_i` pulse.
- R2: After reset `line_cnt_o` holds its maximum value (2^LINE_W-1, 63 by default) and no line is enabled. Further `hsep_i` pulses leave the counter at that maximum.
- R3: `slice_en_o` is high while `line_cnt_o` equals the five-bit programmable line. That line is position-register bits 4:0, written with `cfg_sel_i`=0. Any value from 0 to 31 can be used.
- R4: `slice_en_o` is also high while `line_cnt_o` equals 21, whatever the programmable value is. When the programmable value is 21, a single enable window appears in the field.
- R5: A register write changes nothing in the current field. It takes effect from the next `vsep_i` falling edge.
- R6: `ref_stb_o` is a one-cycle pulse in the cycle the counter enters the reference line. The reference line is chosen by position-register bits 6:5: 0 gives line 21, 1 gives the programmable line, 2 gives line 20 and 3 gives line 19. The pulse fires only in the field whose flag value equals control-register bit 1 (written with `cfg_sel_i`=1).
- R7: `field_o` resets to 0 and changes only on a `vsep_i` falling edge. On an edge in the first half of a line it inverts.
- R8: `field_o` is forced to 1 when `vsep_i` falls at or after half of the most recently measured `hsep_i` period.
- R9: Each sync pulse is counted once, whether it lasts one clock or several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsep_i | input | 1 | Separated horizontal sync, asynchronous |
| vsep_i | input | 1 | Separated vertical sync, asynchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 position, 1 control |
| cfg_data_i | input | 7 | Register write data |
| slice_en_o | output | 1 | High for the whole of a line to be sliced |
| ref_stb_o | output | 1 | One-cycle pulse at the start of the reference-level line |
| field_o | output | 1 | Field flag, 0 for field 1 and 1 for field 2 |
| line_cnt_o | output | LINE_W | Current line count |

## Verification
The hardest case to reach is the forced field-2 decision. It depends on where vertical sync falls relative to a line period that the block measures itself. The bench sends a steady train of horizontal pulses 20 clocks apart, so the measured period is known. It then drops vertical sync either 3 or 14 clocks into a line, once early and twice late in a row, so both the inverting path and the forcing path are exercised. It also sweeps all 32 programmable lines with rotating reference selectors and field selects. A write is placed in the middle of a field to show it is held until the next field.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  typedef enum logic [1:0] {
    REF_FIXED    = 2'd0,
    REF_PROG     = 2'd1,
    REF_FIXED_M1 = 2'd2,
    REF_FIXED_M2 = 2'd3
  } ref_sel_e;

  typedef struct packed {
    ref_sel_e   ref_sel;
    logic [4:0] line;
  } pos_reg_t;

  // Line whose clock run-in sets the slice level.
  function automatic logic [7:0] ref_line_f(input ref_sel_e sel,
                                            input logic [4:0] prog,
                                            input logic [7:0] fixed);
    case (sel)
      REF_FIXED:    return fixed;
      REF_PROG:     return {3'b000, prog};
      REF_FIXED_M1: return fixed - 8'd1;
      default:      return fixed - 8'd2;
    endcase
  endfunction

  // True when the phase has reached half of a known, nonzero period.
  function automatic logic past_half_f(input logic [15:0] phase,
                                       input logic [15:0] period);
    return (period != 16'd0) && (phase >= (period >> 1));
  endfunction

endpackage

// File: rtl/vbi_edge_sync.sv
module vbi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise_o =  chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/vbi_line_counter.sv
module vbi_line_counter #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [LINE_W-1:0] cnt_o,
  output logic              start_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= CNT_MAX;
      start_o <= 1'b0;
    end else begin
      start_o <= clr_i | inc_i;
      if (clr_i)                         cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/vbi_field_track.sv
module vbi_field_track
  import vbi_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_rise_i,
  input  logic v_fall_i,
  output logic late_o,
  output logic field_o
);
  localparam logic [PER_W-1:0] PH_MAX = {PER_W{1'b1}};

  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      period <= '0;
    end else if (h_rise_i) begin
      phase  <= '0;
      period <= phase;
    end else if (phase != PH_MAX) begin
      phase  <= phase + 1'b1;
    end
  end

  assign late_o = past_half_f(16'(phase), 16'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_o <= 1'b0;
    else if (v_fall_i) field_o <= late_o ? 1'b1 : ~field_o;
  end
endmodule

// File: rtl/vbi_line_sel.sv
module vbi_line_sel
  import vbi_pkg::*;
#(
  parameter int LINE_W      = 6,
  parameter int FIXED_LINE  = 21,
  parameter int PER_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsep_i,
  input  logic              vsep_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [6:0]        cfg_data_i,
  output logic              slice_en_o,
  output logic              ref_stb_o,
  output logic              field_o,
  output logic [LINE_W-1:0] line_cnt_o
);
  localparam int N_SYNC = 2;
  localparam logic [7:0] FIXED8 = 8'(FIXED_LINE);

  logic [N_SYNC-1:0] raw_sync, rise_v, fall_v;
  logic h_rise, v_fall, late_fall, line_start, field;
  logic [LINE_W-1:0] line_cnt;
  pos_reg_t pos_pend, pos_act;
  logic fsel_pend, fsel_act;
  logic match_prog, match_fixed, at_ref;

  assign raw_sync = {vsep_i, hsep_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    vbi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_sync[g]),
      .rise_o(rise_v[g]), .fall_o(fall_v[g])
    );
  end

  assign h_rise = rise_v[0];
  assign v_fall = fall_v[1];

  vbi_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(v_fall), .inc_i(h_rise),
    .cnt_o(line_cnt), .start_o(line_start)
  );

  vbi_field_track #(.PER_W(PER_W)) u_field (
    .clk(clk), .rst_n(rst_n), .h_rise_i(h_rise), .v_fall_i(v_fall),
    .late_o(late_fall), .field_o(field)
  );

  // Writes are held, then applied together at the field boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_pend  <= '0;
      pos_act   <= '0;
      fsel_pend <= 1'b0;
      fsel_act  <= 1'b0;
    end else begin
      if (cfg_we_i && !cfg_sel_i) pos_pend  <= pos_reg_t'(cfg_data_i);
      if (cfg_we_i &&  cfg_sel_i) fsel_pend <= cfg_data_i[1];
      if (v_fall) begin
        pos_act  <= pos_pend;
        fsel_act <= fsel_pend;
      end
    end
  end

  assign match_prog  = (line_cnt == LINE_W'(pos_act.line));
  assign match_fixed = (line_cnt == LINE_W'(FIXED_LINE));
  assign at_ref      = (line_cnt == LINE_W'(ref_line_f(pos_act.ref_sel, pos_act.line, FIXED8)));

  assign slice_en_o = match_prog | match_fixed;
  assign ref_stb_o  = line_start & at_ref & (field == fsel_act);
  assign field_o    = field;
  assign line_cnt_o = line_cnt;
endmodule

// File: rtl/vbi_line_sel_chk.sv
module vbi_line_sel_chk #(
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_rise,
  input logic              v_fall,
  input logic              late_fall,
  input logic [LINE_W-1:0] line_cnt,
  input logic              field,
  input logic              ref_stb,
  input logic [6:0]        pos_act,
  input logic              fsel_act
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_fall |=> line_cnt == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rise && !v_fall && line_cnt != CNT_MAX) |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rise && !v_fall && line_cnt == CNT_MAX) |=> line_cnt == CNT_MAX);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_fall |=> ($stable(pos_act) && $stable(fsel_act)));

  // R6
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> !ref_stb);

  // R7
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_fall |=> $stable(field));

  // R7
  field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_fall && !late_fall) |=> field != $past(field));

  // R8
  field_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_fall && late_fall) |=> field);

  // R9
  h_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rise |=> !h_rise);

  // R9
  v_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_fall |=> !v_fall);
endmodule

bind vbi_line_sel vbi_line_sel_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_rise(h_rise), .v_fall(v_fall),
  .late_fall(late_fall), .line_cnt(line_cnt), .field(field),
  .ref_stb(ref_stb_o), .pos_act(pos_act), .fsel_act(fsel_act)
);

// File: tb/test_vbi_line_sel.sv
module test_vbi_line_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsep_i = 1'b0, vsep_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [6:0] cfg_data_i = '0;
  logic slice_en_o, ref_stb_o, field_o;
  logic [5:0] line_cnt_o;

  always #5 clk = ~clk;

  vbi_line_sel i_vbi_line_sel (
    .clk(clk), .rst_n(rst_n), .hsep_i(hsep_i), .vsep_i(vsep_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .slice_en_o(slice_en_o), .ref_stb_o(ref_stb_o), .field_o(field_o),
    .line_cnt_o(line_cnt_o)
  );

  int checks = 0, errors = 0;
  bit [63:0] mask;
  int rises, stb_n, stb_line;
  bit prev_en = 1'b0;
  bit exp_field = 1'b0;
  logic [6:0] pend_pos = '0, act_pos = '0;
  bit pend_fsel = 1'b0, act_fsel = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (slice_en_o) mask[line_cnt_o] = 1'b1;
    if (slice_en_o && !prev_en) rises++;
    prev_en = slice_en_o;
    if (ref_stb_o) begin
      stb_n++;
      stb_line = int'(line_cnt_o);
    end
  end

  function automatic int exp_ref(input logic [6:0] pos);
    int prog = int'(pos[4:0]);
    case (pos[6:5])
      2'd0: return 21;
      2'd1: return prog;
      2'd2: return 21 - 1;
      default: return 21 - 2;
    endcase
  endfunction

  task automatic wr(input bit sel, input logic [6:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (sel) pend_fsel = d[1]; else pend_pos = d;
  endtask

  task automatic run_line(input int w, input bit vf, input int off);
    for (int c = 0; c < 20; c++) begin
      hsep_i = (c < w);
      if (vf) vsep_i = (c < off);
      @(negedge clk);
    end
  endtask

  task automatic run_field(input int n, input int off, input int w,
                           input int wr_at, input logic [6:0] wr_val);
    mask = '0; rises = 0; stb_n = 0; stb_line = -1;
    run_line(w, 1'b1, off);
    act_pos = pend_pos; act_fsel = pend_fsel;
    exp_field = (off >= 10) ? 1'b1 : ~exp_field;
    for (int i = 0; i < n; i++) begin
      if (i == wr_at) wr(1'b0, wr_val);
      run_line(w, 1'b0, 0);
    end
  endtask

  task automatic check_field(input int n);
    int p = int'(act_pos[4:0]);
    bit [63:0] em = (64'd1 << p) | (64'd1 << 21);
    bit want = (exp_field == act_fsel);
    chk("R1", "line count", int'(line_cnt_o), (n > 63) ? 63 : n);
    chk("R3", "enabled lines low word", int'(mask[31:0]), int'(em[31:0]));
    chk("R4", "enabled lines high word", int'(mask[63:32]), int'(em[63:32]));
    chk("R6", "strobe count", stb_n, want ? 1 : 0);
    if (want) chk("R6", "strobe line", stb_line, exp_ref(act_pos));
    chk("R7", "field flag", int'(field_o), int'(exp_field));
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset count", int'(line_cnt_o), 63);
    chk("R2", "reset slice enable", int'(slice_en_o), 0);
    chk("R6", "reset strobe", int'(ref_stb_o), 0);
    chk("R7", "reset field", int'(field_o), 0);

    mask = '0; stb_n = 0;
    for (int i = 0; i < 4; i++) run_line(2, 1'b0, 0);
    chk("R2", "count held before first field", int'(line_cnt_o), 63);
    chk("R2", "no line enabled before first field", int'(mask != 0), 0);
    chk("R2", "no strobe before first field", stb_n, 0);

    // R3 R4 R6 R7 sweep of every programmable line
    for (int p = 0; p < 32; p++) begin
      wr(1'b0, {2'(p % 4), 5'(p)});
      wr(1'b1, {5'd0, 1'((p / 3) % 2), 1'b0});
      run_field(35, 3, 2, -1, '0);
      check_field(35);
      if (p == 21) chk("R4", "single window when lines coincide", rises, 1);
      else chk("R3", "enable windows", rises, (p == 20 || p == 22) ? 1 : 2);
    end

    // R5 write in the middle of a field
    wr(1'b0, {2'd1, 5'd7});
    run_field(35, 3, 2, 4, {2'd1, 5'd12});
    chk("R5", "old line still used", int'(mask[7]), 1);
    chk("R5", "new line not yet used", int'(mask[12]), 0);
    run_field(35, 3, 2, -1, '0);
    chk("R5", "new line used next field", int'(mask[12]), 1);
    chk("R5", "old line dropped", int'(mask[7]), 0);
    check_field(35);

    // R8 late vertical sync forces field 2
    run_field(10, 14, 2, -1, '0);
    chk("R8", "late fall forces field", int'(field_o), 1);
    run_field(10, 14, 2, -1, '0);
    chk("R8", "second late fall keeps field", int'(field_o), 1);
    run_field(10, 3, 2, -1, '0);
    chk("R7", "early fall inverts field", int'(field_o), 0);

    // R9 pulse width does not change the count
    run_field(12, 3, 1, -1, '0);
    chk("R9", "one-clock pulses", int'(line_cnt_o), 12);
    run_field(12, 3, 6, -1, '0);
    chk("R9", "six-clock pulses", int'(line_cnt_o), 12);

    // R2 saturation inside a long field
    run_field(70, 3, 2, -1, '0);
    check_field(70);
    chk("R2", "saturated count", int'(line_cnt_o), 63);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule